// File: doc/BRIEF.md
# Error-Syndrome System Register Access Unit

This unit is the system-register slice for a reliability feature that reports errors without keeping any error records. Each access arrives as a five-field register encoding, a read/write flag and the current exception level (0 to 3). Alongside it come the hypervisor controls (effective abort routing, error-register trap) and the secure-monitor controls (external-abort routing, error-register trap). Within the same cycle the unit picks one outcome: success with read data, trap to EL2, trap to EL3, or undefined. A successful write lands on the next rising clock edge.

The unit holds three 64-bit registers: the deferred error status, its virtual twin and the virtual error syndrome. Guest accesses to the deferred status register can be steered to the virtual twin, or turned into read-as-zero/write-ignored, depending on the level and the routing controls. A constant ID register reports zero error records, so the record selector and the indexed record registers do not exist.

The house style centres on a state machine, but this block has no sequential control. All state lives in the three data registers, and the decode, check and route stages form one combinational chain.

Top module: `ras_sysreg_unit`

## Requirements
- R1: The deferred status register (op0=3, op1=0, CRn=12, CRm=1, op2=1) is readable and writable at EL1 and above. When neither redirection rule applies, the access acts on the physical register.
- R2: An access to the deferred status register below EL2 while the hypervisor abort-routing control is set reads and writes the virtual deferred status register instead. This rule takes precedence over R3.
- R3: Otherwise, an access to the deferred status register below EL3 while the monitor external-abort routing control is set reads zero and leaves all storage unchanged on a write.
- R4: The error-record ID register (op0=3, op1=0, CRn=5, CRm=3, op2=0) reads zero at EL1 and above. A write to it is undefined.
- R5: An untrapped-level read of the ID register below EL2 while the hypervisor error-trap control is set traps to EL2. This check outranks R6.
- R6: A read of the ID register below EL3 while the monitor error-trap control is set, and R5 not applying, traps to EL3.
- R7: The virtual deferred status register (3,4,12,1,1) and the virtual syndrome register (3,4,5,2,3) are plain read/write registers at EL2 and above.
- R8: The record selector (3,0,5,3,1), the indexed record registers (3,0,5,4,x and 3,0,5,5,x) and every other encoding not listed here are undefined.
- R9: An access from a level below the register's minimum level (EL1 for the deferred status and ID registers, EL2 for the virtual ones) is undefined and changes no storage.
- R10: All three registers reset to zero. A register changes only on a clock edge where a valid write to it completes with success.
- R11: A valid access asserts exactly one of ok, trap2, trap3, undef. With no valid access, none is asserted. Read data is zero unless the result is a successful read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| acc_el | input | 2 | Current exception level |
| hyp_amo | input | 1 | Effective hypervisor abort-routing control |
| hyp_terr | input | 1 | Hypervisor error-register trap control |
| mon_ea | input | 1 | Monitor external-abort routing control |
| mon_terr | input | 1 | Monitor error-register trap control |
| acc_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Read data, combinational |
| rsp_ok | output | 1 | Access succeeds |
| rsp_trap2 | output | 1 | Access traps to EL2 |
| rsp_trap3 | output | 1 | Access traps to EL3 |
| rsp_undef | output | 1 | Access is undefined |

## Verification
The checker assumes that every access input, including the four control bits, stays constant from one rising edge to the next. It relies on this to relate a cycle's result to the register update seen after that edge, and to judge the read data against the stored values in the same cycle. The bench changes every input only on the falling edge and samples a little after it, so each access is one stable cycle. All four exception levels and every combination of controls that matters to the precedence rules appear in the stimulus.

// File: rtl/ras_sysreg_pkg.sv
package ras_sysreg_pkg;

    localparam int OP0_W = 2;
    localparam int OP1_W = 3;
    localparam int CRN_W = 4;
    localparam int CRM_W = 4;
    localparam int OP2_W = 3;
    localparam int EL_W  = 2;

    typedef struct packed {
        logic [OP0_W-1:0] op0;
        logic [OP1_W-1:0] op1;
        logic [CRN_W-1:0] crn;
        logic [CRM_W-1:0] crm;
        logic [OP2_W-1:0] op2;
    } sysreg_enc_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DSTAT,
        SEL_ERRID,
        SEL_VDSTAT,
        SEL_VSYND
    } reg_sel_e;

    typedef enum logic [1:0] {
        RES_OK,
        RES_TRAP2,
        RES_TRAP3,
        RES_UNDEF
    } result_e;

    // Storage index is the route value for the three stored registers.
    typedef enum logic [1:0] {
        ROUTE_PHYS = 2'd0,
        ROUTE_VIRT = 2'd1,
        ROUTE_SYND = 2'd2,
        ROUTE_RAZ  = 2'd3
    } route_e;

    localparam int NUM_STORE = 3;

    typedef struct packed {
        sysreg_enc_t     enc;
        reg_sel_e        sel;
        logic [EL_W-1:0] min_el;
        logic            read_only;
    } sysreg_def_t;

    localparam int NUM_DEF = 4;

    localparam sysreg_def_t DEF_TABLE [NUM_DEF] = '{
        '{enc: '{op0: 2'd3, op1: 3'd0, crn: 4'd12, crm: 4'd1, op2: 3'd1},
          sel: SEL_DSTAT,  min_el: 2'd1, read_only: 1'b0},
        '{enc: '{op0: 2'd3, op1: 3'd0, crn: 4'd5,  crm: 4'd3, op2: 3'd0},
          sel: SEL_ERRID,  min_el: 2'd1, read_only: 1'b1},
        '{enc: '{op0: 2'd3, op1: 3'd4, crn: 4'd12, crm: 4'd1, op2: 3'd1},
          sel: SEL_VDSTAT, min_el: 2'd2, read_only: 1'b0},
        '{enc: '{op0: 2'd3, op1: 3'd4, crn: 4'd5,  crm: 4'd2, op2: 3'd3},
          sel: SEL_VSYND,  min_el: 2'd2, read_only: 1'b0}
    };

endpackage

// File: rtl/ras_sysreg_decode.sv
module ras_sysreg_decode
    import ras_sysreg_pkg::*;
(
    input  sysreg_enc_t     enc,
    output reg_sel_e        sel,
    output logic [EL_W-1:0] min_el,
    output logic            read_only
);

    // Table search: an encoding missing from the table is undefined.
    always_comb begin
        sel       = SEL_NONE;
        min_el    = '1;
        read_only = 1'b0;
        for (int i = 0; i < NUM_DEF; i++) begin
            if (enc == DEF_TABLE[i].enc) begin
                sel       = DEF_TABLE[i].sel;
                min_el    = DEF_TABLE[i].min_el;
                read_only = DEF_TABLE[i].read_only;
            end
        end
    end

endmodule

// File: rtl/ras_sysreg_policy.sv
module ras_sysreg_policy
    import ras_sysreg_pkg::*;
(
    input  logic            acc_write,
    input  logic [EL_W-1:0] acc_el,
    input  reg_sel_e        sel,
    input  logic [EL_W-1:0] min_el,
    input  logic            read_only,
    input  logic            hyp_amo,
    input  logic            hyp_terr,
    input  logic            mon_ea,
    input  logic            mon_terr,
    output result_e         result,
    output route_e          route
);

    logic below_el2;
    logic below_el3;

    assign below_el2 = (acc_el < 2'd2);
    assign below_el3 = (acc_el < 2'd3);

    // Check order: existence, level, direction, traps, then routing.
    always_comb begin
        result = RES_OK;
        route  = ROUTE_RAZ;
        if (sel == SEL_NONE || acc_el < min_el || (acc_write && read_only)) begin
            result = RES_UNDEF;
        end else if (sel == SEL_ERRID && below_el2 && hyp_terr) begin
            result = RES_TRAP2;
        end else if (sel == SEL_ERRID && below_el3 && mon_terr) begin
            result = RES_TRAP3;
        end else begin
            unique case (sel)
                SEL_DSTAT: begin
                    if (below_el2 && hyp_amo) begin
                        route = ROUTE_VIRT;
                    end else if (below_el3 && mon_ea) begin
                        route = ROUTE_RAZ;
                    end else begin
                        route = ROUTE_PHYS;
                    end
                end
                SEL_VDSTAT: route = ROUTE_VIRT;
                SEL_VSYND:  route = ROUTE_SYND;
                SEL_ERRID:  route = ROUTE_RAZ;
                SEL_NONE:   route = ROUTE_RAZ;
            endcase
        end
    end

endmodule

// File: rtl/ras_sysreg_store.sv
module ras_sysreg_store
    import ras_sysreg_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  route_e                           route,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_STORE-1:0][DATA_W-1:0] bank_q
);

    for (genvar g = 0; g < NUM_STORE; g++) begin : g_reg
        logic hit;
        assign hit = wr_en && (route == route_e'(2'(g)));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else if (hit) begin
                bank_q[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/ras_sysreg_unit.sv
module ras_sysreg_unit
    import ras_sysreg_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_op0,
    input  logic [2:0]        acc_op1,
    input  logic [3:0]        acc_crn,
    input  logic [3:0]        acc_crm,
    input  logic [2:0]        acc_op2,
    input  logic [1:0]        acc_el,
    input  logic              hyp_amo,
    input  logic              hyp_terr,
    input  logic              mon_ea,
    input  logic              mon_terr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_ok,
    output logic              rsp_trap2,
    output logic              rsp_trap3,
    output logic              rsp_undef
);

    sysreg_enc_t     enc;
    reg_sel_e        sel;
    logic [EL_W-1:0] min_el;
    logic            read_only;
    result_e         result;
    route_e          route;
    logic            wr_en;
    logic [NUM_STORE-1:0][DATA_W-1:0] bank_q;
    logic [DATA_W-1:0] phys_q;
    logic [DATA_W-1:0] virt_q;
    logic [DATA_W-1:0] synd_q;
    logic [DATA_W-1:0] read_mux;

    assign enc = '{op0: acc_op0, op1: acc_op1, crn: acc_crn, crm: acc_crm, op2: acc_op2};

    ras_sysreg_decode u_decode (
        .enc       (enc),
        .sel       (sel),
        .min_el    (min_el),
        .read_only (read_only)
    );

    ras_sysreg_policy u_policy (
        .acc_write (acc_write),
        .acc_el    (acc_el),
        .sel       (sel),
        .min_el    (min_el),
        .read_only (read_only),
        .hyp_amo   (hyp_amo),
        .hyp_terr  (hyp_terr),
        .mon_ea    (mon_ea),
        .mon_terr  (mon_terr),
        .result    (result),
        .route     (route)
    );

    assign wr_en = acc_valid && acc_write && (result == RES_OK);

    ras_sysreg_store #(.DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .route  (route),
        .wdata  (acc_wdata),
        .bank_q (bank_q)
    );

    assign phys_q = bank_q[ROUTE_PHYS];
    assign virt_q = bank_q[ROUTE_VIRT];
    assign synd_q = bank_q[ROUTE_SYND];

    always_comb begin
        unique case (route)
            ROUTE_PHYS: read_mux = phys_q;
            ROUTE_VIRT: read_mux = virt_q;
            ROUTE_SYND: read_mux = synd_q;
            ROUTE_RAZ:  read_mux = '0;
        endcase
    end

    always_comb begin
        rsp_ok    = acc_valid && (result == RES_OK);
        rsp_trap2 = acc_valid && (result == RES_TRAP2);
        rsp_trap3 = acc_valid && (result == RES_TRAP3);
        rsp_undef = acc_valid && (result == RES_UNDEF);
        rsp_rdata = (rsp_ok && !acc_write) ? read_mux : '0;
    end

endmodule

// File: rtl/ras_sysreg_checker.sv
module ras_sysreg_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [1:0]        acc_op0,
    input logic [2:0]        acc_op1,
    input logic [3:0]        acc_crn,
    input logic [3:0]        acc_crm,
    input logic [2:0]        acc_op2,
    input logic [1:0]        acc_el,
    input logic              hyp_amo,
    input logic              hyp_terr,
    input logic              mon_ea,
    input logic              mon_terr,
    input logic [DATA_W-1:0] acc_wdata,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_ok,
    input logic              rsp_trap2,
    input logic              rsp_trap3,
    input logic              rsp_undef,
    input logic [DATA_W-1:0] phys_q,
    input logic [DATA_W-1:0] virt_q,
    input logic [DATA_W-1:0] synd_q
);

    logic [15:0] enc;
    logic        is_dstat;
    logic        is_errid;
    logic        is_vsynd;
    logic        good_read;
    logic        good_write;

    assign enc        = {acc_op0, acc_op1, acc_crn, acc_crm, acc_op2};
    assign is_dstat   = (enc == {2'd3, 3'd0, 4'd12, 4'd1, 3'd1});
    assign is_errid   = (enc == {2'd3, 3'd0, 4'd5, 4'd3, 3'd0});
    assign is_vsynd   = (enc == {2'd3, 3'd4, 4'd5, 4'd2, 3'd3});
    assign good_read  = rsp_ok && !acc_write;
    assign good_write = acc_valid && acc_write && rsp_ok;

    assert_one_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $countones({rsp_ok, rsp_trap2, rsp_trap3, rsp_undef}) == 1);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> {rsp_ok, rsp_trap2, rsp_trap3, rsp_undef} == 4'b0);

    assert_rdata_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !good_read |-> rsp_rdata == '0);

    assert_phys_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (good_read && is_dstat && acc_el == 2'd3) |-> rsp_rdata == phys_q);

    assert_virt_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (good_read && is_dstat && acc_el < 2'd2 && hyp_amo) |-> rsp_rdata == virt_q);

    assert_raz_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (good_read && is_dstat && acc_el < 2'd3 && mon_ea && !(acc_el < 2'd2 && hyp_amo))
        |-> rsp_rdata == '0);

    assert_id_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (good_read && is_errid) |-> rsp_rdata == '0);

    assert_trap2_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap2 |-> (is_errid && acc_el < 2'd2 && hyp_terr));

    assert_trap3_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap3 |-> (is_errid && acc_el < 2'd3 && mon_terr && !(acc_el < 2'd2 && hyp_terr)));

    assert_low_level_undef_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_el == 2'd0) |-> rsp_undef);

    assert_phys_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !good_write |=> $stable(phys_q));

    assert_virt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !good_write |=> $stable(virt_q));

    assert_synd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !good_write |=> $stable(synd_q));

    assert_synd_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (good_write && is_vsynd) |=> synd_q == $past(acc_wdata));

endmodule

bind ras_sysreg_unit ras_sysreg_checker #(.DATA_W(DATA_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_op0   (acc_op0),
    .acc_op1   (acc_op1),
    .acc_crn   (acc_crn),
    .acc_crm   (acc_crm),
    .acc_op2   (acc_op2),
    .acc_el    (acc_el),
    .hyp_amo   (hyp_amo),
    .hyp_terr  (hyp_terr),
    .mon_ea    (mon_ea),
    .mon_terr  (mon_terr),
    .acc_wdata (acc_wdata),
    .rsp_rdata (rsp_rdata),
    .rsp_ok    (rsp_ok),
    .rsp_trap2 (rsp_trap2),
    .rsp_trap3 (rsp_trap3),
    .rsp_undef (rsp_undef),
    .phys_q    (phys_q),
    .virt_q    (virt_q),
    .synd_q    (synd_q)
);

// File: tb/ras_sysreg_unit_bench.sv
module ras_sysreg_unit_bench;

    localparam logic [15:0] E_DS  = {2'd3, 3'd0, 4'd12, 4'd1, 3'd1};
    localparam logic [15:0] E_ID  = {2'd3, 3'd0, 4'd5,  4'd3, 3'd0};
    localparam logic [15:0] E_VDS = {2'd3, 3'd4, 4'd12, 4'd1, 3'd1};
    localparam logic [15:0] E_VSY = {2'd3, 3'd4, 4'd5,  4'd2, 3'd3};
    localparam logic [15:0] E_SEL = {2'd3, 3'd0, 4'd5,  4'd3, 3'd1};
    localparam logic [15:0] E_REC = {2'd3, 3'd0, 4'd5,  4'd4, 3'd2};

    // control bits {amo, hyp_terr, mon_ea, mon_terr}
    localparam logic [3:0] C0 = 4'b0000;
    localparam logic [3:0] CA = 4'b1000;
    localparam logic [3:0] CH = 4'b0100;
    localparam logic [3:0] CE = 4'b0010;
    localparam logic [3:0] CM = 4'b0001;

    // result codes: 0 ok, 1 trap EL2, 2 trap EL3, 3 undefined
    localparam logic [1:0] OK = 2'd0, T2 = 2'd1, T3 = 2'd2, UD = 2'd3;

    localparam logic [63:0] DA = 64'hA5A5_0000_1111_2222;
    localparam logic [63:0] DB = 64'h0000_BEEF_0000_0001;
    localparam logic [63:0] DC = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] DD = 64'h8000_0000_0000_0003;
    localparam logic [63:0] DE = 64'h1234_5678_9ABC_DEF0;
    localparam logic [63:0] DF = 64'h0000_0000_0000_0F0F;
    localparam logic [63:0] DG = 64'h0000_0000_0000_0077;
    localparam logic [63:0] DH = 64'h0000_0000_0000_0088;

    typedef struct packed {
        logic        wr;
        logic [15:0] enc;
        logic [1:0]  el;
        logic [3:0]  ctl;
        logic [63:0] wdata;
        logic [1:0]  res;
        logic [63:0] rdata;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{1'b1, E_DS,  2'd1, C0,      DA,  OK, 64'd0, 8'd1},
        '{1'b0, E_DS,  2'd1, C0,      '0,  OK, DA,    8'd1},
        '{1'b1, E_DS,  2'd1, CA,      DB,  OK, 64'd0, 8'd2},
        '{1'b0, E_DS,  2'd1, CA,      '0,  OK, DB,    8'd2},
        '{1'b0, E_DS,  2'd2, CA,      '0,  OK, DA,    8'd2},
        '{1'b0, E_VDS, 2'd2, C0,      '0,  OK, DB,    8'd7},
        '{1'b1, E_DS,  2'd1, CE,      DC,  OK, 64'd0, 8'd3},
        '{1'b0, E_DS,  2'd1, CE,      '0,  OK, 64'd0, 8'd3},
        '{1'b0, E_DS,  2'd3, CE,      '0,  OK, DA,    8'd3},
        '{1'b0, E_DS,  2'd2, CE,      '0,  OK, 64'd0, 8'd3},
        '{1'b0, E_DS,  2'd1, CA | CE, '0,  OK, DB,    8'd2},
        '{1'b0, E_ID,  2'd1, C0,      '0,  OK, 64'd0, 8'd4},
        '{1'b0, E_ID,  2'd1, CH | CM, '0,  T2, 64'd0, 8'd5},
        '{1'b0, E_ID,  2'd2, CH | CM, '0,  T3, 64'd0, 8'd6},
        '{1'b0, E_ID,  2'd3, CH | CM, '0,  OK, 64'd0, 8'd6},
        '{1'b0, E_ID,  2'd0, CH | CM, '0,  UD, 64'd0, 8'd9},
        '{1'b1, E_ID,  2'd1, C0,      DE,  UD, 64'd0, 8'd4},
        '{1'b1, E_VSY, 2'd2, C0,      DD,  OK, 64'd0, 8'd7},
        '{1'b0, E_VSY, 2'd3, C0,      '0,  OK, DD,    8'd7},
        '{1'b0, E_VSY, 2'd1, C0,      '0,  UD, 64'd0, 8'd9},
        '{1'b1, E_VDS, 2'd1, C0,      DE,  UD, 64'd0, 8'd9},
        '{1'b0, E_VDS, 2'd2, C0,      '0,  OK, DB,    8'd9},
        '{1'b0, E_SEL, 2'd1, C0,      '0,  UD, 64'd0, 8'd8},
        '{1'b0, E_REC, 2'd3, C0,      '0,  UD, 64'd0, 8'd8},
        '{1'b0, E_DS,  2'd0, C0,      '0,  UD, 64'd0, 8'd9},
        '{1'b1, E_DS,  2'd0, C0,      DF,  UD, 64'd0, 8'd9},
        '{1'b0, E_DS,  2'd3, C0,      '0,  OK, DA,    8'd9},
        '{1'b1, E_VDS, 2'd3, C0,      DG,  OK, 64'd0, 8'd7},
        '{1'b0, E_DS,  2'd1, CA,      '0,  OK, DG,    8'd2},
        '{1'b0, E_ID,  2'd1, CM,      '0,  T3, 64'd0, 8'd6},
        '{1'b1, E_DS,  2'd2, CA,      DH,  OK, 64'd0, 8'd1},
        '{1'b0, E_DS,  2'd3, C0,      '0,  OK, DH,    8'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_op0 = '0;
    logic [2:0]  acc_op1 = '0;
    logic [3:0]  acc_crn = '0;
    logic [3:0]  acc_crm = '0;
    logic [2:0]  acc_op2 = '0;
    logic [1:0]  acc_el = '0;
    logic        hyp_amo = 1'b0;
    logic        hyp_terr = 1'b0;
    logic        mon_ea = 1'b0;
    logic        mon_terr = 1'b0;
    logic [63:0] acc_wdata = '0;
    logic [63:0] rsp_rdata;
    logic        rsp_ok;
    logic        rsp_trap2;
    logic        rsp_trap3;
    logic        rsp_undef;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ras_sysreg_unit u_ras_sysreg_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_op0   (acc_op0),
        .acc_op1   (acc_op1),
        .acc_crn   (acc_crn),
        .acc_crm   (acc_crm),
        .acc_op2   (acc_op2),
        .acc_el    (acc_el),
        .hyp_amo   (hyp_amo),
        .hyp_terr  (hyp_terr),
        .mon_ea    (mon_ea),
        .mon_terr  (mon_terr),
        .acc_wdata (acc_wdata),
        .rsp_rdata (rsp_rdata),
        .rsp_ok    (rsp_ok),
        .rsp_trap2 (rsp_trap2),
        .rsp_trap3 (rsp_trap3),
        .rsp_undef (rsp_undef)
    );

    task automatic drive(input logic v, input logic wr, input logic [15:0] enc,
                         input logic [1:0] el, input logic [3:0] ctl, input logic [63:0] wd);
        @(negedge clk);
        acc_valid = v;
        acc_write = wr;
        {acc_op0, acc_op1, acc_crn, acc_crm, acc_op2} = enc;
        acc_el = el;
        {hyp_amo, hyp_terr, mon_ea, mon_terr} = ctl;
        acc_wdata = wd;
        #1;
    endtask

    task automatic expect_out(input logic [3:0] exp_ind, input logic [63:0] exp_rd,
                              input string tag);
        logic [3:0] got;
        got = {rsp_ok, rsp_trap2, rsp_trap3, rsp_undef};
        n_checks++;
        if (got !== exp_ind || rsp_rdata !== exp_rd) begin
            n_fail++;
            $display("FAIL %s: ind=%b rdata=%h expected ind=%b rdata=%h",
                     tag, got, rsp_rdata, exp_ind, exp_rd);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state of all three registers, read at EL3
        drive(1'b1, 1'b0, E_DS, 2'd3, C0, '0);
        expect_out(4'b1000, 64'd0, "R10 reset phys");
        drive(1'b1, 1'b0, E_VDS, 2'd3, C0, '0);
        expect_out(4'b1000, 64'd0, "R10 reset virt");
        drive(1'b1, 1'b0, E_VSY, 2'd3, C0, '0);
        expect_out(4'b1000, 64'd0, "R10 reset synd");

        // R11: no valid access gives no indication and no write
        drive(1'b0, 1'b1, E_DS, 2'd3, C0, DC);
        expect_out(4'b0000, 64'd0, "R11 idle");
        drive(1'b1, 1'b0, E_DS, 2'd3, C0, '0);
        expect_out(4'b1000, 64'd0, "R11 idle write dropped");

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VEC[i].wr, VEC[i].enc, VEC[i].el, VEC[i].ctl, VEC[i].wdata);
            expect_out(4'b1000 >> VEC[i].res, VEC[i].rdata,
                       $sformatf("R%0d vector %0d", VEC[i].req, i));
        end

        // R8: second indexed record group
        drive(1'b1, 1'b1, {2'd3, 3'd0, 4'd5, 4'd5, 3'd0}, 2'd3, C0, DC);
        expect_out(4'b0001, 64'd0, "R8 record group two");

        // R10: mid-run reset clears everything
        @(negedge clk);
        acc_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 1'b0, E_DS, 2'd3, C0, '0);
        expect_out(4'b1000, 64'd0, "R10 rereset phys");
        drive(1'b1, 1'b0, E_VDS, 2'd3, C0, '0);
        expect_out(4'b1000, 64'd0, "R10 rereset virt");
        drive(1'b1, 1'b0, E_VSY, 2'd3, C0, '0);
        expect_out(4'b1000, 64'd0, "R10 rereset synd");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule